// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block turns a decoded addressing mode into an operand. A request carries a mode code, an address field A, a register number R and the current program counter. The unit chains the dependent data-memory reads that mode needs: none, one, or two when a pointer must be fetched first. It then presents the operand, the effective address of the final read, and the number of reads it issued. A one-cycle done pulse marks the result.

The register file is read through a combinational select/data port. Memory reads use a synchronous port. A read is offered with a valid/ready handshake, and the read word must appear on the data input in the cycle after the handshake completes. Address sums wrap modulo 2^AW. Register and memory words feed address arithmetic through their low AW bits. The top register, index NREG-1, serves as the stack pointer.

Top module: `opf_fetch_unit`

## Requirements
- R1: Mode code 0 (immediate), and any code 10 to 15, gives operand = A zero-extended, ea = 0, acc_cnt = 0, and issues no memory read.
- R2: Mode code 3 (register) gives operand = full contents of register R, ea = 0, acc_cnt = 0, and issues no memory read.
- R3: Mode code 1 (direct) issues exactly one read at address A. The operand is the word read, ea = A and acc_cnt = 1.
- R4: Mode code 2 (indirect) reads address A first. It then reads at the low AW bits of that word. The operand is the second word, ea = that pointer and acc_cnt = 2.
- R5: Mode code 4 (register indirect) issues one read at (R). Mode code 9 (stack) issues one read at the contents of register NREG-1. In both, ea is that address and acc_cnt = 1.
- R6: Mode code 5 (relative) issues one read at PC + A. Mode code 6 (base register) issues one read at (R) + A. Both sums wrap modulo 2^AW, ea is the sum and acc_cnt = 1.
- R7: Mode code 7 (pre-index) reads at A + (R). It then reads at the pointer held in that word. ea = the pointer and acc_cnt = 2.
- R8: Mode code 8 (post-index) reads at A. It adds (R) to the word read, modulo 2^AW, and reads at that sum. ea = the sum and acc_cnt = 2.
- R9: Reads go out in the order the mode defines. A read holds rd_valid and rd_addr until rd_ready. The returned word is taken from rd_data in the cycle after the handshake.
- R10: done is high for exactly one cycle per request. operand, ea and acc_cnt keep their values until the next done.
- R11: A request is accepted only when req_valid and req_ready are both high. req_ready is high only while idle. Request inputs presented while busy are ignored.
- R12: After reset, done = 0, rd_valid = 0 and req_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle; request taken on this cycle if valid |
| req_mode | input | 4 | Addressing mode code |
| req_afield | input | AW | Address field A |
| req_reg | input | $clog2(NREG) | Register number R |
| req_pc | input | AW | Current program counter |
| rf_sel | output | $clog2(NREG) | Register file read select |
| rf_data | input | DW | Register file read data |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | AW | Memory read address |
| rd_data | input | DW | Read word, valid the cycle after handshake |
| done | output | 1 | One-cycle result pulse |
| operand | output | DW | Fetched operand |
| ea | output | AW | Effective address of the final read (0 if none) |
| acc_cnt | output | 2 | Memory reads used by the last request |

## Verification
A corrupted step counter or latched mode shows up at the ports within one request. It would produce a wrong number of handshakes, a wrong acc_cnt, or a second read issued where none belongs. A wrong pointer register shows on rd_addr at the very next handshake. The bench therefore compares the whole address sequence of each request, not just the final operand. A stuck or mis-decoded sequencer shows as a missing done or a request accepted while busy. The overlapping garbage requests make such an error change the result of the operation in flight.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_DIR  = 4'd1,
        AM_IND  = 4'd2,
        AM_REG  = 4'd3,
        AM_RIND = 4'd4,
        AM_REL  = 4'd5,
        AM_BASE = 4'd6,
        AM_PRE  = 4'd7,
        AM_POST = 4'd8,
        AM_STK  = 4'd9
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_READ = 2'd2,
        ST_RESP = 2'd3
    } st_e;

endpackage

// File: rtl/opf_mode_plan.sv
// Decides, per mode, how many reads are needed and where the first one goes.
module opf_mode_plan
    import opf_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] afield,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] rval,
    output logic [1:0]    reads,
    output logic          from_reg,
    output logic [AW-1:0] first_addr
);

    always_comb begin
        reads      = 2'd0;
        from_reg   = 1'b0;
        first_addr = '0;
        case (am_e'(mode))
            AM_DIR:  begin reads = 2'd1; first_addr = afield;        end
            AM_IND:  begin reads = 2'd2; first_addr = afield;        end
            AM_REG:  begin reads = 2'd0; from_reg   = 1'b1;          end
            AM_RIND: begin reads = 2'd1; first_addr = rval;          end
            AM_REL:  begin reads = 2'd1; first_addr = pc + afield;   end
            AM_BASE: begin reads = 2'd1; first_addr = rval + afield; end
            AM_PRE:  begin reads = 2'd2; first_addr = afield + rval; end
            AM_POST: begin reads = 2'd2; first_addr = afield;        end
            AM_STK:  begin reads = 2'd1; first_addr = rval;          end
            default: begin reads = 2'd0;                             end
        endcase
    end

    // R1: unknown and immediate codes never ask for memory
    always_comb begin
        if (mode == 4'd0 || mode > 4'd9)
            assert_imm_no_read_R1: assert (reads == 2'd0 && !from_reg);
    end

endmodule

// File: rtl/opf_chain_step.sv
// Forms the second read address from the word returned by the first read.
module opf_chain_step
    import opf_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] rval,
    output logic [AW-1:0] next_addr
);

    always_comb begin
        case (am_e'(mode))
            AM_POST: next_addr = ptr + rval;
            default: next_addr = ptr;
        endcase
    end

endmodule

// File: rtl/opf_fetch_unit.sv
module opf_fetch_unit
    import opf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 12,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [3:0]              req_mode,
    input  logic [AW-1:0]           req_afield,
    input  logic [$clog2(NREG)-1:0] req_reg,
    input  logic [AW-1:0]           req_pc,
    output logic [$clog2(NREG)-1:0] rf_sel,
    input  logic [DW-1:0]           rf_data,
    output logic                    rd_valid,
    input  logic                    rd_ready,
    output logic [AW-1:0]           rd_addr,
    input  logic [DW-1:0]           rd_data,
    output logic                    done,
    output logic [DW-1:0]           operand,
    output logic [AW-1:0]           ea,
    output logic [1:0]              acc_cnt
);

    localparam int RW = $clog2(NREG);
    localparam logic [RW-1:0] SP_IDX = RW'(NREG - 1);

    typedef struct packed {
        st_e           st;
        logic [3:0]    mode;
        logic [AW-1:0] afield;
        logic [RW-1:0] rsel;
        logic [AW-1:0] pc;
        logic [AW-1:0] addr;
        logic [1:0]    cnt;
        logic [1:0]    need;
        logic          done;
        logic [DW-1:0] opnd;
        logic [AW-1:0] ea;
        logic [1:0]    acc;
    } state_t;

    state_t s_d, s_q;

    logic [AW-1:0] rval, ptr, first_addr, next_addr;
    logic [1:0]    reads;
    logic          from_reg;

    // Low AW bits of register and memory words feed address arithmetic.
    generate
        if (DW == AW) begin : g_same_width
            assign rval = rf_data;
            assign ptr  = rd_data;
        end else begin : g_wide_data
            assign rval = rf_data[AW-1:0];
            assign ptr  = rd_data[AW-1:0];
        end
    endgenerate

    assign rf_sel = (am_e'(s_q.mode) == AM_STK) ? SP_IDX : s_q.rsel;

    opf_mode_plan #(.AW(AW)) plan_i (
        .mode       (s_q.mode),
        .afield     (s_q.afield),
        .pc         (s_q.pc),
        .rval       (rval),
        .reads      (reads),
        .from_reg   (from_reg),
        .first_addr (first_addr)
    );

    opf_chain_step #(.AW(AW)) step_i (
        .mode      (s_q.mode),
        .ptr       (ptr),
        .rval      (rval),
        .next_addr (next_addr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.mode   = req_mode;
                    s_d.afield = req_afield;
                    s_d.rsel   = req_reg;
                    s_d.pc     = req_pc;
                    s_d.st     = ST_CALC;
                end
            end
            ST_CALC: begin
                if (reads == 2'd0) begin
                    s_d.done = 1'b1;
                    s_d.opnd = from_reg ? rf_data : DW'(s_q.afield);
                    s_d.ea   = '0;
                    s_d.acc  = 2'd0;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.addr = first_addr;
                    s_d.need = reads;
                    s_d.cnt  = 2'd0;
                    s_d.st   = ST_READ;
                end
            end
            ST_READ: begin
                if (rd_ready) begin
                    s_d.cnt = s_q.cnt + 2'd1;
                    s_d.st  = ST_RESP;
                end
            end
            default: begin
                if (s_q.cnt == s_q.need) begin
                    s_d.done = 1'b1;
                    s_d.opnd = rd_data;
                    s_d.ea   = s_q.addr;
                    s_d.acc  = s_q.cnt;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.addr = next_addr;
                    s_d.st   = ST_READ;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign rd_valid  = (s_q.st == ST_READ);
    assign rd_addr   = s_q.addr;
    assign done      = s_q.done;
    assign operand   = s_q.opnd;
    assign ea        = s_q.ea;
    assign acc_cnt   = s_q.acc;

    // R9: an offered read stays put until taken
    assert_read_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R10: done never lasts two cycles
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results hold between pulses
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(operand) && $stable(ea) && $stable(acc_cnt));

    // R11: an accepted request makes the unit busy at once
    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !done);

    // R11: no memory traffic while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    // R1: a result with no reads carries a zero address
    assert_no_read_no_ea_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done && acc_cnt == 2'd0 |-> ea == '0);

endmodule

// File: tb/opf_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module opf_fetch_unit_tb_top;

    localparam int DW   = 16;
    localparam int AW   = 12;
    localparam int NREG = 8;
    localparam int RW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_mode = '0;
    logic [AW-1:0] req_afield = '0;
    logic [RW-1:0] req_reg = '0;
    logic [AW-1:0] req_pc = '0;
    logic [RW-1:0] rf_sel;
    logic [DW-1:0] rf_data;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          done;
    logic [DW-1:0] operand;
    logic [AW-1:0] ea;
    logic [1:0]    acc_cnt;

    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] mseed = 16'h5a5a;
    int            rdy_mode = 0;
    int            nhs = 0;
    logic [AW-1:0] seen [4];
    logic          pend = 1'b0;
    logic [AW-1:0] paddr = '0;
    int            checks = 0;
    int            fails = 0;

    always #2.5 clk = ~clk;

    assign rf_data = regs[rf_sel];

    opf_fetch_unit #(.DW(DW), .AW(AW), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
        .req_afield(req_afield), .req_reg(req_reg), .req_pc(req_pc),
        .rf_sel(rf_sel), .rf_data(rf_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .operand(operand), .ea(ea), .acc_cnt(acc_cnt)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return DW'(a * 16'd40503) ^ mseed;
    endfunction

    // Memory model: ready chosen at the falling edge, data one cycle after handshake.
    always @(negedge clk) begin
        if (rdy_mode == 0) rd_ready = 1'b1;
        else               rd_ready = (($urandom % 100) < 55);
        if (rd_valid && rd_ready) begin
            if (nhs < 4) seen[nhs] = rd_addr;
            nhs   = nhs + 1;
            pend  = 1'b1;
            paddr = rd_addr;
        end else begin
            pend = 1'b0;
        end
    end

    always @(posedge clk) if (pend) rd_data <= memf(paddr);

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R2";
            4'd4, 4'd9: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic expect_of(input logic [3:0] m, input logic [AW-1:0] a,
                             input logic [RW-1:0] r, input logic [AW-1:0] pc,
                             output logic [DW-1:0] op, output logic [AW-1:0] e,
                             output int n, output logic [AW-1:0] a0,
                             output logic [AW-1:0] a1);
        logic [AW-1:0] rv, sp;
        rv = regs[r][AW-1:0];
        sp = regs[NREG-1][AW-1:0];
        a0 = '0; a1 = '0; e = '0; n = 0;
        op = DW'(a);
        case (m)
            4'd1: begin n = 1; a0 = a; e = a; end
            4'd2: begin n = 2; a0 = a; a1 = memf(a)[AW-1:0]; e = a1; end
            4'd3: begin op = regs[r]; end
            4'd4: begin n = 1; a0 = rv; e = rv; end
            4'd5: begin n = 1; a0 = pc + a; e = a0; end
            4'd6: begin n = 1; a0 = rv + a; e = a0; end
            4'd7: begin n = 2; a0 = a + rv; a1 = memf(a0)[AW-1:0]; e = a1; end
            4'd8: begin n = 2; a0 = a; a1 = memf(a)[AW-1:0] + rv; e = a1; end
            4'd9: begin n = 1; a0 = sp; e = sp; end
            default: ;
        endcase
        if (n > 0) op = memf(e);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [3:0] m, input logic [AW-1:0] a,
                           input logic [RW-1:0] r, input logic [AW-1:0] pc,
                           input bit garbage);
        logic [DW-1:0] eop;
        logic [AW-1:0] eea, a0, a1;
        logic [DW-1:0] hop;
        logic [AW-1:0] hea;
        logic [1:0]    hcnt;
        int en, guard;
        string t;
        t = tag_of(m);
        expect_of(m, a, r, pc, eop, eea, en, a0, a1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nhs = 0;
        req_valid = 1'b1; req_mode = m; req_afield = a; req_reg = r; req_pc = pc;
        @(negedge clk);
        guard = 0;
        req_valid = 1'b0;
        while (!done && guard < 2000) begin
            if (garbage) begin
                req_valid  = 1'b1;
                req_mode   = 4'($urandom);
                req_afield = AW'($urandom);
                req_reg    = RW'($urandom);
                req_pc     = AW'($urandom);
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        chk(done, t, "done seen", done, 1);
        chk(operand == eop, garbage ? "R11" : t, "operand", operand, eop);
        chk(ea == eea, t, "effective address", ea, eea);
        chk(acc_cnt == 2'(en), t, "access count", acc_cnt, en);
        chk(nhs == en, "R9", "handshake count", nhs, en);
        if (en > 0 && nhs > 0) chk(seen[0] == a0, "R9", "first read address", seen[0], a0);
        if (en > 1 && nhs > 1) chk(seen[1] == a1, "R9", "second read address", seen[1], a1);
        hop = operand; hea = ea; hcnt = acc_cnt;
        @(negedge clk);
        chk(!done, "R10", "done width", done, 0);
        chk(operand == hop && ea == hea && acc_cnt == hcnt, "R10", "result hold",
            operand, hop);
    endtask

    task automatic fill_regs();
        for (int i = 0; i < NREG; i++) regs[i] = DW'($urandom);
        mseed = DW'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) regs[i] = DW'(i * 16'h1111);
        repeat (3) @(negedge clk);
        chk(!done && !rd_valid && req_ready, "R12", "reset outputs",
            {done, rd_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rd_valid && req_ready, "R12", "idle after reset",
            {done, rd_valid, req_ready}, 3'b001);

        // Directed: every mode once with zero-wait memory
        rdy_mode = 0;
        fill_regs();
        for (int m = 0; m < 10; m++) run_vec(4'(m), 12'h123, 3'd2, 12'h400, 1'b0);
        run_vec(4'd12, 12'hABC, 3'd1, 12'h010, 1'b0);   // R1 unknown code
        run_vec(4'd15, 12'h001, 3'd1, 12'h010, 1'b0);   // R1 unknown code
        // Wrap corners for R6, R7 and R8
        regs[3] = 16'hFFFF;
        run_vec(4'd5, 12'hFFF, 3'd3, 12'hFFF, 1'b0);
        run_vec(4'd6, 12'h002, 3'd3, 12'h000, 1'b0);
        run_vec(4'd7, 12'hFFF, 3'd3, 12'h000, 1'b0);
        run_vec(4'd8, 12'hFFE, 3'd3, 12'h000, 1'b0);
        // Stack pointer register is the top one (R5)
        regs[NREG-1] = 16'h0F0F;
        run_vec(4'd9, 12'h000, 3'd0, 12'h000, 1'b0);
        // Slow memory and overlapping requests (R9, R11)
        rdy_mode = 1;
        for (int m = 0; m < 10; m++) run_vec(4'(m), 12'h3C5, 3'd5, 12'h7F0, 1'b1);

        // Constrained random
        for (int k = 0; k < 300; k++) begin
            fill_regs();
            rdy_mode = int'($urandom % 2);
            run_vec(4'($urandom % 11 == 10 ? 4'd10 + 4'($urandom % 6) : 4'($urandom % 10)),
                    AW'($urandom), RW'($urandom), AW'($urandom), ($urandom % 3) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule